// File: doc/BRIEF.md
# Interrupt Request Front End

This block sits between a CPU core and its external event pins. It conditions three kinds of request. The first is a level-sensitive maskable request that carries a 4-bit priority level. The second is an active-low nonmaskable request that counts on its high-to-low transition and is then held. The third is an active-low reset pin, which is honoured only after it has stayed low for a minimum number of clocks. Every pin passes through a resettable synchroniser of `SYNC_STAGES` flops, so a request that lands too close to one rising edge is taken at a later edge.

For the winning event the block shows a request flag and the fixed handler address. Reset wins over the nonmaskable request, and the nonmaskable request wins over the maskable one. The core answers with three inputs. One says the maskable request was taken. One says nonmaskable handling has started. One marks the short window in which the core clears its nonmaskable latch. The core also feeds back its nonmaskable in-service status bit. A qualified reset drops every pending and taken state.

Top module: `irqfe_top`

## Requirements
- R1: `irq_req` follows the synchronised maskable request with no latching. It rises and falls `SYNC_STAGES` clocks after the pin, unless suppressed by R4, R8 or R10. `irq_lvl` shows the synchronised level. `vec_valid` is high whenever any request output is high.
- R2: While `irq_req` is high, `vec_addr` is 0xFE00_0000 + 16·level when `vec_base_iram` is 1, and 0xFFFF_FE00 + 16·level when it is 0.
- R3: `lvl_rsvd` is high exactly when `irq_req` is high and the level is 15.
- R4: A cycle with `irq_req` and `int_ack` both high masks the request from the next cycle on. The mask lasts until the synchronised request is seen low, or until a strictly higher level is seen.
- R5: A synchronised high sample followed by a low sample of `nmi_pin_n` sets a pending flag, shown on `nmi_req`. The flag stays set when the pin returns high. It clears only on `nmi_start_ack`. A pin that stays low does not set it again.
- R6: While `nmi_req` is high and reset is not held, `vec_addr` is 0xFFFF_FFD0.
- R7: An edge that arrives while `nmi_in_service` is 1 and `nmi_clr_win` is 0 is retained. An edge that arrives while both are 1 is discarded.
- R8: A pending nonmaskable request forces `irq_req` low.
- R9: `rst_hold` rises once the synchronised `rst_pin_n` has been low for `RST_MIN_LOW` consecutive samples. A shorter low run has no effect. While `rst_hold` is high, `vec_addr` is 0xFFFF_FFF0. `rst_hold` falls one clock after the synchronised pin is seen high.
- R10: While `rst_hold` is high, `irq_req` and `nmi_req` are low. The pending nonmaskable flag and the R4 mask are cleared.
- R11: After `arst_n`, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| arst_n | input | 1 | Asynchronous block reset, active low |
| int_req | input | 1 | Maskable request level, active high |
| int_lvl | input | 4 | Maskable priority level |
| nmi_pin_n | input | 1 | Nonmaskable request, falling edge |
| rst_pin_n | input | 1 | External reset request, active low |
| vec_base_iram | input | 1 | 1: maskable handlers in internal RAM; 0: external memory |
| nmi_in_service | input | 1 | Core status: nonmaskable handler running |
| nmi_clr_win | input | 1 | Core is clearing its nonmaskable latch |
| int_ack | input | 1 | Core accepted the maskable request |
| nmi_start_ack | input | 1 | Core started nonmaskable handling |
| irq_req | output | 1 | Maskable request to core |
| irq_lvl | output | 4 | Synchronised level |
| lvl_rsvd | output | 1 | Reserved level 15 requested |
| nmi_req | output | 1 | Nonmaskable request pending |
| rst_hold | output | 1 | Qualified reset active |
| vec_valid | output | 1 | `vec_addr` is meaningful |
| vec_addr | output | 32 | Handler address of the winning event |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 and `RST_MIN_LOW` = 5. Three stages make the pin-to-output latency longer than any single-cycle acknowledge pulse, so overlaps between delayed edges and acknowledges can be reached. The short qualification length allows a low run of exactly one sample too few, followed by a full run, within a few dozen clocks. Directed sequences cover base switching, level-15 flagging, masking and re-arming after a higher level, edges retained or discarded around the latch-clear window, and a reset that flushes a pending nonmaskable request.

// File: rtl/irqfe_pkg.sv
package irqfe_pkg;

  localparam int LVL_W  = 4;
  localparam int ADDR_W = 32;

  localparam logic [ADDR_W-1:0] RST_VEC       = 32'hFFFF_FFF0;
  localparam logic [ADDR_W-1:0] NMI_VEC       = 32'hFFFF_FFD0;
  localparam logic [ADDR_W-1:0] MASK_BASE_INT = 32'hFE00_0000;
  localparam logic [ADDR_W-1:0] MASK_BASE_EXT = 32'hFFFF_FE00;
  localparam logic [LVL_W-1:0]  LVL_RESERVED  = 4'hF;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_MASK = 2'd1,
    EV_NMI  = 2'd2,
    EV_RST  = 2'd3
  } ev_kind_t;

  // Maskable handler: base chosen by the base-select bit, level in bits 7:4.
  function automatic logic [ADDR_W-1:0] mask_vector(input logic [LVL_W-1:0] lvl,
                                                    input logic iram);
    logic [ADDR_W-1:0] base;
    base = iram ? MASK_BASE_INT : MASK_BASE_EXT;
    return base | {{(ADDR_W-LVL_W-4){1'b0}}, lvl, 4'h0};
  endfunction

  function automatic logic lvl_is_reserved(input logic [LVL_W-1:0] lvl);
    return lvl == LVL_RESERVED;
  endfunction

  function automatic logic lvl_outranks(input logic [LVL_W-1:0] now_lvl,
                                        input logic [LVL_W-1:0] old_lvl);
    return now_lvl > old_lvl;
  endfunction

  function automatic logic [ADDR_W-1:0] event_vector(input ev_kind_t k,
                                                     input logic [LVL_W-1:0] lvl,
                                                     input logic iram);
    case (k)
      EV_RST:  return RST_VEC;
      EV_NMI:  return NMI_VEC;
      EV_MASK: return mask_vector(lvl, iram);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/irqfe_sync.sv
module irqfe_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) stg[0] <= RST_VAL;
      else         stg[0] <= d;
    end
  end else begin : g_chain
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) stg <= {STAGES{RST_VAL}};
      else         stg <= {stg[STAGES-2:0], d};
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/irqfe_rst_qual.sv
module irqfe_rst_qual #(
  parameter int MIN_LOW = 20
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pin_s,
  output logic hold
);

  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_LOW);

  logic [CW-1:0] run_q;

  assign hold = (run_q == LIMIT);

  // Consecutive low samples, saturating at the limit; any high sample restarts.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)    run_q <= '0;
    else if (pin_s) run_q <= '0;
    else if (!hold) run_q <= run_q + CW'(1);
  end

endmodule

// File: rtl/irqfe_nmi_latch.sv
module irqfe_nmi_latch (
  input  logic clk,
  input  logic arst_n,
  input  logic pin_s,
  input  logic busy,
  input  logic clr_win,
  input  logic start_ack,
  input  logic flush,
  output logic pend,
  output logic fall,
  output logic drop
);

  logic prev_q;
  logic pend_q;

  assign fall = prev_q & ~pin_s;
  assign drop = fall & busy & clr_win;
  assign pend = pend_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= pin_s;
      if (flush) pend_q <= 1'b0;
      else       pend_q <= (pend_q & ~start_ack) | (fall & ~drop);
    end
  end

endmodule

// File: rtl/irqfe_mask_track.sv
module irqfe_mask_track
  import irqfe_pkg::*;
(
  input  logic             clk,
  input  logic             arst_n,
  input  logic             req_s,
  input  logic [LVL_W-1:0] lvl_s,
  input  logic             ack,
  input  logic             block,
  input  logic             flush,
  output logic             req_out,
  output logic             taken
);

  logic             taken_q;
  logic [LVL_W-1:0] tlvl_q;
  logic             rearm;

  assign req_out = req_s & ~taken_q & ~block;
  assign rearm   = taken_q & (~req_s | lvl_outranks(lvl_s, tlvl_q));
  assign taken   = taken_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      taken_q <= 1'b0;
      tlvl_q  <= '0;
    end else if (flush) begin
      taken_q <= 1'b0;
      tlvl_q  <= '0;
    end else if (req_out & ack) begin
      taken_q <= 1'b1;
      tlvl_q  <= lvl_s;
    end else if (rearm) begin
      taken_q <= 1'b0;
    end
  end

endmodule

// File: rtl/irqfe_top.sv
module irqfe_top
  import irqfe_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_MIN_LOW = 20
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              int_req,
  input  logic [LVL_W-1:0]  int_lvl,
  input  logic              nmi_pin_n,
  input  logic              rst_pin_n,
  input  logic              vec_base_iram,
  input  logic              nmi_in_service,
  input  logic              nmi_clr_win,
  input  logic              int_ack,
  input  logic              nmi_start_ack,
  output logic              irq_req,
  output logic [LVL_W-1:0]  irq_lvl,
  output logic              lvl_rsvd,
  output logic              nmi_req,
  output logic              rst_hold,
  output logic              vec_valid,
  output logic [ADDR_W-1:0] vec_addr
);

  localparam int PIN_W = LVL_W + 3;
  localparam logic [PIN_W-1:0] PIN_IDLE = {1'b1, 1'b1, {LVL_W{1'b0}}, 1'b0};

  logic [PIN_W-1:0] pins_s;
  logic             req_s;
  logic [LVL_W-1:0] lvl_s;
  logic             nmi_s;
  logic             rst_s;
  logic             nmi_pend;
  logic             nmi_fall;
  logic             nmi_drop;
  logic             mask_taken;
  logic             mask_block;
  ev_kind_t         ev_kind;

  irqfe_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) sync_i (
    .clk   (clk),
    .arst_n(arst_n),
    .d     ({rst_pin_n, nmi_pin_n, int_lvl, int_req}),
    .q     (pins_s)
  );

  assign {rst_s, nmi_s, lvl_s, req_s} = pins_s;

  irqfe_rst_qual #(.MIN_LOW(RST_MIN_LOW)) rstq_i (
    .clk   (clk),
    .arst_n(arst_n),
    .pin_s (rst_s),
    .hold  (rst_hold)
  );

  irqfe_nmi_latch nmi_i (
    .clk      (clk),
    .arst_n   (arst_n),
    .pin_s    (nmi_s),
    .busy     (nmi_in_service),
    .clr_win  (nmi_clr_win),
    .start_ack(nmi_start_ack),
    .flush    (rst_hold),
    .pend     (nmi_pend),
    .fall     (nmi_fall),
    .drop     (nmi_drop)
  );

  assign mask_block = nmi_pend | rst_hold;

  irqfe_mask_track mask_i (
    .clk    (clk),
    .arst_n (arst_n),
    .req_s  (req_s),
    .lvl_s  (lvl_s),
    .ack    (int_ack),
    .block  (mask_block),
    .flush  (rst_hold),
    .req_out(irq_req),
    .taken  (mask_taken)
  );

  assign nmi_req  = nmi_pend & ~rst_hold;
  assign irq_lvl  = lvl_s;
  assign lvl_rsvd = irq_req & lvl_is_reserved(lvl_s);

  always_comb begin
    if (rst_hold)     ev_kind = EV_RST;
    else if (nmi_req) ev_kind = EV_NMI;
    else if (irq_req) ev_kind = EV_MASK;
    else              ev_kind = EV_NONE;
  end

  assign vec_valid = (ev_kind != EV_NONE);
  assign vec_addr  = event_vector(ev_kind, lvl_s, vec_base_iram);

endmodule

// File: rtl/irqfe_chk.sv
module irqfe_chk (
  input logic        clk,
  input logic        arst_n,
  input logic        irq_req,
  input logic [3:0]  irq_lvl,
  input logic        lvl_rsvd,
  input logic        nmi_req,
  input logic        rst_hold,
  input logic [31:0] vec_addr,
  input logic        vec_base_iram,
  input logic        int_ack,
  input logic        nmi_start_ack,
  input logic        rst_s,
  input logic        nmi_pend,
  input logic        nmi_fall,
  input logic        nmi_drop
);

  // R5
  nmi_edge_latch_chk: assert property (@(posedge clk) disable iff (!arst_n)
    nmi_fall && !nmi_drop && !rst_hold |=> nmi_pend);

  // R5
  nmi_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    nmi_pend && !nmi_start_ack && !rst_hold |=> nmi_pend);

  // R7
  nmi_discard_chk: assert property (@(posedge clk) disable iff (!arst_n)
    nmi_drop && (!nmi_pend || nmi_start_ack) |=> !nmi_pend);

  // R8
  nmi_over_irq_chk: assert property (@(posedge clk) disable iff (!arst_n)
    nmi_req |-> !irq_req);

  // R4
  ack_masks_chk: assert property (@(posedge clk) disable iff (!arst_n)
    irq_req && int_ack |=> !irq_req);

  // R3
  rsvd_flag_chk: assert property (@(posedge clk) disable iff (!arst_n)
    lvl_rsvd |-> irq_req && irq_lvl == 4'hF);

  // R2
  iram_vec_chk: assert property (@(posedge clk) disable iff (!arst_n)
    irq_req && vec_base_iram |-> vec_addr[31:8] == 24'hFE0000 &&
                                 vec_addr[7:4] == irq_lvl && vec_addr[3:0] == 4'h0);

  // R9
  rst_vec_chk: assert property (@(posedge clk) disable iff (!arst_n)
    rst_hold |-> vec_addr == 32'hFFFF_FFF0);

  // R9
  rst_needs_low_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_hold) |-> !$past(rst_s));

  // R10
  rst_flush_chk: assert property (@(posedge clk) disable iff (!arst_n)
    rst_hold |=> !nmi_pend);

endmodule

bind irqfe_top irqfe_chk chk_i (
  .clk          (clk),
  .arst_n       (arst_n),
  .irq_req      (irq_req),
  .irq_lvl      (irq_lvl),
  .lvl_rsvd     (lvl_rsvd),
  .nmi_req      (nmi_req),
  .rst_hold     (rst_hold),
  .vec_addr     (vec_addr),
  .vec_base_iram(vec_base_iram),
  .int_ack      (int_ack),
  .nmi_start_ack(nmi_start_ack),
  .rst_s        (rst_s),
  .nmi_pend     (nmi_pend),
  .nmi_fall     (nmi_fall),
  .nmi_drop     (nmi_drop)
);

// File: tb/irqfe_top_tb_top.sv
`timescale 1ns/1ps
module irqfe_top_tb_top;

  localparam int SYNC = 3;
  localparam int RMIN = 5;

  logic clk = 1'b0;
  logic arst_n, int_req, nmi_pin_n, rst_pin_n, vec_base_iram;
  logic nmi_in_service, nmi_clr_win, int_ack, nmi_start_ack;
  logic [3:0] int_lvl;
  logic irq_req, lvl_rsvd, nmi_req, rst_hold, vec_valid;
  logic [3:0] irq_lvl;
  logic [31:0] vec_addr;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;
  bit rst_seen = 0;

  always #2.5 clk = ~clk;

  irqfe_top #(.SYNC_STAGES(SYNC), .RST_MIN_LOW(RMIN)) dut_i (
    .clk(clk), .arst_n(arst_n), .int_req(int_req), .int_lvl(int_lvl),
    .nmi_pin_n(nmi_pin_n), .rst_pin_n(rst_pin_n), .vec_base_iram(vec_base_iram),
    .nmi_in_service(nmi_in_service), .nmi_clr_win(nmi_clr_win), .int_ack(int_ack),
    .nmi_start_ack(nmi_start_ack), .irq_req(irq_req), .irq_lvl(irq_lvl),
    .lvl_rsvd(lvl_rsvd), .nmi_req(nmi_req), .rst_hold(rst_hold),
    .vec_valid(vec_valid), .vec_addr(vec_addr));

  // Reference model: pin history queue, run length, pending and served state.
  bit [6:0] hist[$];
  int low_run, served_lvl;
  bit nmi_hold, served, prev_n;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    hist.delete();
    for (int i = 0; i < SYNC; i++) hist.push_front(7'b110_0000);
    low_run = 0; served_lvl = 0; nmi_hold = 0; served = 0; prev_n = 1;
  endtask

  task automatic model_step();
    bit [6:0] s;
    bit rst_on, fall, irq_now;
    s = hist[$];
    rst_on  = low_run >= RMIN;
    fall    = prev_n && !s[5];
    irq_now = s[0] && !served && !nmi_hold && !rst_on;
    if (rst_on) begin
      nmi_hold = 0; served = 0; served_lvl = 0;
    end else begin
      nmi_hold = (nmi_hold && !nmi_start_ack) || (fall && !(nmi_in_service && nmi_clr_win));
      if (irq_now && int_ack) begin
        served = 1; served_lvl = int'(s[4:1]);
      end else if (served && (!s[0] || int'(s[4:1]) > served_lvl)) begin
        served = 0;
      end
    end
    low_run = s[6] ? 0 : ((low_run < RMIN) ? low_run + 1 : RMIN);
    prev_n  = s[5];
    hist.push_front({rst_pin_n, nmi_pin_n, int_lvl, int_req});
    void'(hist.pop_back());
  endtask

  task automatic compare();
    bit [6:0] s;
    bit e_rst, e_nmi, e_irq;
    int lvl;
    logic [31:0] e_vec;
    s = hist[$];
    lvl = int'(s[4:1]);
    e_rst = low_run >= RMIN;
    e_nmi = nmi_hold && !e_rst;
    e_irq = s[0] && !served && !nmi_hold && !e_rst;
    if (e_rst) e_vec = 32'hFFFF_FFF0;
    else if (e_nmi) e_vec = 32'hFFFF_FFD0;
    else if (e_irq) e_vec = (vec_base_iram ? 32'hFE00_0000 : 32'hFFFF_FE00) + 32'(lvl * 16);
    else e_vec = 0;
    chk("R1 irq_req", 32'(irq_req), 32'(e_irq));
    chk("R1 irq_lvl", 32'(irq_lvl), 32'(lvl));
    chk("R1 vec_valid", 32'(vec_valid), 32'(e_rst || e_nmi || e_irq));
    chk("R3 lvl_rsvd", 32'(lvl_rsvd), 32'(e_irq && lvl == 15));
    chk("R5 nmi_req", 32'(nmi_req), 32'(e_nmi));
    chk("R9 rst_hold", 32'(rst_hold), 32'(e_rst));
    chk(e_rst ? "R9 vec_addr" : (e_nmi ? "R6 vec_addr" : "R2 vec_addr"), vec_addr, e_vec);
  endtask

  always @(posedge clk) begin
    if (!arst_n) model_reset();
    else model_step();
    #1;
    if (arst_n && !done) compare();
    if (rst_hold) rst_seen = 1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    arst_n = 0; int_req = 0; int_lvl = 0; nmi_pin_n = 1; rst_pin_n = 1;
    vec_base_iram = 1; nmi_in_service = 0; nmi_clr_win = 0; int_ack = 0; nmi_start_ack = 0;
    tick(3);
    arst_n = 1;
    tick(1);
    // R11 reset state
    chk("R11 irq_req", 32'(irq_req), 0);
    chk("R11 nmi_req", 32'(nmi_req), 0);
    chk("R11 rst_hold", 32'(rst_hold), 0);
    chk("R11 vec_valid", 32'(vec_valid), 0);
    chk("R11 vec_addr", vec_addr, 0);

    // R1 / R2: level 3, both bases
    int_lvl = 3; int_req = 1; tick(SYNC + 1);
    chk("R1 irq up", 32'(irq_req), 1);
    chk("R2 iram vec", vec_addr, 32'hFE00_0030);
    vec_base_iram = 0; tick(1);
    chk("R2 ext vec", vec_addr, 32'hFFFF_FE30);

    // R3: reserved level
    int_lvl = 15; tick(SYNC + 1);
    chk("R3 rsvd on", 32'(lvl_rsvd), 1);
    chk("R2 ext vec l15", vec_addr, 32'hFFFF_FEF0);
    int_lvl = 5; tick(SYNC + 1);
    chk("R3 rsvd off", 32'(lvl_rsvd), 0);

    // R4: masking after accept, re-arm by higher level and by release
    int_ack = 1; tick(1); int_ack = 0; tick(SYNC + 1);
    chk("R4 masked", 32'(irq_req), 0);
    int_lvl = 4; tick(SYNC + 1);
    chk("R4 lower stays masked", 32'(irq_req), 0);
    int_lvl = 9; tick(SYNC + 1);
    chk("R4 higher rearms", 32'(irq_req), 1);
    int_ack = 1; tick(1); int_ack = 0;
    int_req = 0; tick(SYNC + 1);
    chk("R1 irq drops", 32'(irq_req), 0);
    int_req = 1; tick(SYNC + 1);
    chk("R4 rearm after low", 32'(irq_req), 1);

    // R5 / R6 / R8
    nmi_pin_n = 0; tick(2); nmi_pin_n = 1; tick(SYNC + 2);
    chk("R5 nmi latched", 32'(nmi_req), 1);
    chk("R6 nmi vec", vec_addr, 32'hFFFF_FFD0);
    chk("R8 irq suppressed", 32'(irq_req), 0);
    nmi_start_ack = 1; nmi_in_service = 1; tick(1); nmi_start_ack = 0; tick(1);
    chk("R5 nmi cleared", 32'(nmi_req), 0);
    chk("R8 irq returns", 32'(irq_req), 1);

    // R7 retained while in service
    nmi_pin_n = 0; tick(SYNC + 2);
    chk("R7 retained", 32'(nmi_req), 1);
    nmi_start_ack = 1; tick(1); nmi_start_ack = 0; tick(SYNC + 3);
    chk("R5 steady low no retrigger", 32'(nmi_req), 0);

    // R7 discarded in clear window
    nmi_pin_n = 1; tick(SYNC + 2);
    nmi_clr_win = 1; tick(1);
    nmi_pin_n = 0; tick(SYNC + 2);
    nmi_clr_win = 0; tick(2);
    chk("R7 discarded", 32'(nmi_req), 0);
    nmi_in_service = 0; nmi_pin_n = 1; tick(SYNC + 2);

    // R9 one sample short
    rst_seen = 0;
    rst_pin_n = 0; tick(RMIN - 1); rst_pin_n = 1; tick(SYNC + 3);
    chk("R9 short run ignored", 32'(rst_seen), 0);

    // R10: reset flushes a pending nmi
    nmi_pin_n = 0; tick(SYNC + 2);
    chk("R5 nmi before reset", 32'(nmi_req), 1);
    rst_pin_n = 0; tick(SYNC + RMIN + 1);
    chk("R9 hold", 32'(rst_hold), 1);
    chk("R9 reset vec", vec_addr, 32'hFFFF_FFF0);
    chk("R10 nmi gated", 32'(nmi_req), 0);
    chk("R10 irq gated", 32'(irq_req), 0);
    rst_pin_n = 1; nmi_pin_n = 1; tick(SYNC + 2);
    chk("R9 released", 32'(rst_hold), 0);
    chk("R10 nmi flushed", 32'(nmi_req), 0);
    chk("R10 irq after reset", 32'(irq_req), 1);

    tick(2);
    finish_run();
  end

endmodule